// File: doc/BRIEF.md
# USB Line State Override

This block sits between a USB packet engine and the bus transceiver. In normal operation it passes the engine's D+ drive, D− drive and output enable through unchanged. A two-bit force code from the control register can instead override the engine. The code can drive a bus reset (both lines low), a J state or a K state. While the code is active the transceiver enable is held on and the engine's drive has no effect.

A directly attached low-speed device uses the opposite line polarity. Firmware marks this case by setting both the low-speed bit and the polarity-swap bit. With both bits set, the D+/D− levels of the forced J and K codes are exchanged. The forced-reset code also raises a hold output that keeps the packet engine in reset. Firmware starts a bus reset by writing the reset code and ends it by writing the pass code. Firmware also times how long the reset lasts. All outputs go through one register stage, so they change one clock after the inputs.

Top module: `usb_line_force`

## Requirements
- R1: While reset (rstN low) is asserted, lineDp, lineDm, lineOe and engineHold are all 0.
- R2: With forceCode = 2'b00 (bit 1 is control bit 4, bit 0 is control bit 3), lineDp, lineDm and lineOe equal txDp, txDm and txOe of the previous clock.
- R3: With forceCode = 2'b01, one clock later lineDp = 0, lineDm = 0 and lineOe = 1 (single-ended zero).
- R4: With forceCode = 2'b10 and swap inactive, one clock later lineDp = 1, lineDm = 0 and lineOe = 1.
- R5: With forceCode = 2'b11 and swap inactive, one clock later lineDp = 0, lineDm = 1 and lineOe = 1.
- R6: Swap is active only when lowSpeed = 1 and polSwap = 1. With swap active, code 2'b10 gives lineDp = 0 and lineDm = 1, and code 2'b11 gives lineDp = 1 and lineDm = 0. lineOe is 1 in both cases.
- R7: With exactly one of lowSpeed and polSwap set, forced J and K levels are the same as in R4 and R5.
- R8: For any nonzero forceCode, txDp, txDm and txOe have no effect on the outputs, and lineOe = 1.
- R9: engineHold is 1 one clock after forceCode = 2'b01, and 0 one clock after any other code.
- R10: lowSpeed and polSwap have no effect in pass mode (code 2'b00) or on the forced-reset code 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| forceCode | input | 2 | Force code: {control bit 4, control bit 3} |
| lowSpeed | input | 1 | Low-speed mode bit |
| polSwap | input | 1 | Line polarity swap bit |
| txDp | input | 1 | Engine D+ drive |
| txDm | input | 1 | Engine D− drive |
| txOe | input | 1 | Engine output enable |
| lineDp | output | 1 | D+ to transceiver |
| lineDm | output | 1 | D− to transceiver |
| lineOe | output | 1 | Output enable to transceiver |
| engineHold | output | 1 | Holds the packet engine in reset |

## Verification
A wrong decode or a swap gated on the wrong condition shows at the ports as an exchanged or wrong D+/D− pair. It appears exactly one clock after the offending code is applied. A force path that does not fully shut out the engine shows up as output values that follow txDp, txDm or txOe while a code is active. The stimulus walks every combination of code, speed bit, swap bit and engine drive, so each such fault is caught on the first clock where that combination occurs.

// File: rtl/usb_line_force_pkg.sv
package usb_line_force_pkg;

  typedef enum logic [1:0] {
    CODE_PASS = 2'b00,
    CODE_SE0  = 2'b01,
    CODE_J    = 2'b10,
    CODE_K    = 2'b11
  } forceCode_e;

  typedef struct packed {
    logic forceActive;
    logic driveSe0;
    logic driveDpHigh;
    logic driveDmHigh;
    logic holdEngine;
  } lineStrb_t;

endpackage

// File: rtl/usb_line_force_ctrl.sv
module usb_line_force_ctrl
  import usb_line_force_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] forceCode,
  input  logic      lowSpeed,
  input  logic      polSwap,
  output lineStrb_t strb
);

  forceCode_e code;
  logic swapJk;

  assign code   = forceCode_e'(forceCode);
  assign swapJk = lowSpeed & polSwap;

  always_comb begin
    strb = '0;
    unique case (code)
      CODE_PASS: ;
      CODE_SE0: begin
        strb.forceActive = 1'b1;
        strb.driveSe0    = 1'b1;
        strb.holdEngine  = 1'b1;
      end
      CODE_J: begin
        strb.forceActive = 1'b1;
        strb.driveDpHigh = ~swapJk;
        strb.driveDmHigh = swapJk;
      end
      CODE_K: begin
        strb.forceActive = 1'b1;
        strb.driveDpHigh = swapJk;
        strb.driveDmHigh = ~swapJk;
      end
      default: ;
    endcase
  end

  // R8: a forced code selects exactly one line level
  p_one_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceActive |-> ($countones({strb.driveSe0, strb.driveDpHigh, strb.driveDmHigh}) == 1));

  // R6: with swap active the J code drives D- high
  p_swap_j_r6: assert property (@(posedge clk) disable iff (!rstN)
    (forceCode == 2'b10 && lowSpeed && polSwap) |-> strb.driveDmHigh);

  // R7: one bit alone does not exchange levels
  p_no_swap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (forceCode == 2'b10 && !(lowSpeed && polSwap)) |-> strb.driveDpHigh);

endmodule

// File: rtl/usb_line_force_dp.sv
module usb_line_force_dp
  import usb_line_force_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  lineStrb_t strb,
  input  logic      txDp,
  input  logic      txDm,
  input  logic      txOe,
  output logic      lineDp,
  output logic      lineDm,
  output logic      lineOe,
  output logic      engineHold
);

  logic nextDp, nextDm, nextOe;

  always_comb begin
    if (strb.forceActive) begin
      nextDp = strb.driveDpHigh;
      nextDm = strb.driveDmHigh;
      nextOe = 1'b1;
    end else begin
      nextDp = txDp;
      nextDm = txDm;
      nextOe = txOe;
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      logic dpQ, dmQ, oeQ, holdQ, liveQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dpQ   <= 1'b0;
          dmQ   <= 1'b0;
          oeQ   <= 1'b0;
          holdQ <= 1'b0;
          liveQ <= 1'b0;
        end else begin
          dpQ   <= nextDp;
          dmQ   <= nextDm;
          oeQ   <= nextOe;
          holdQ <= strb.holdEngine;
          liveQ <= 1'b1;
        end
      end

      assign lineDp     = dpQ;
      assign lineDm     = dmQ;
      assign lineOe     = oeQ;
      assign engineHold = holdQ;

      p_se0_r3: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && $past(strb.driveSe0)) |-> (!lineDp && !lineDm && lineOe));

      p_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && !$past(strb.forceActive)) |->
          (lineDp == $past(txDp) && lineDm == $past(txDm) && lineOe == $past(txOe)));

      p_force_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && $past(strb.forceActive)) |-> lineOe);

      p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
        liveQ |-> (engineHold == $past(strb.holdEngine)));
    end else begin : g_comb
      assign lineDp     = nextDp;
      assign lineDm     = nextDm;
      assign lineOe     = nextOe;
      assign engineHold = strb.holdEngine;

      p_force_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
        strb.forceActive |-> lineOe);
    end
  endgenerate

endmodule

// File: rtl/usb_line_force.sv
module usb_line_force
  import usb_line_force_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] forceCode,
  input  logic       lowSpeed,
  input  logic       polSwap,
  input  logic       txDp,
  input  logic       txDm,
  input  logic       txOe,
  output logic       lineDp,
  output logic       lineDm,
  output logic       lineOe,
  output logic       engineHold
);

  lineStrb_t strb;

  usb_line_force_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .forceCode (forceCode),
    .lowSpeed  (lowSpeed),
    .polSwap   (polSwap),
    .strb      (strb)
  );

  usb_line_force_dp #(.OUT_REG(OUT_REG)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .txDp       (txDp),
    .txDm       (txDm),
    .txOe       (txOe),
    .lineDp     (lineDp),
    .lineDm     (lineDm),
    .lineOe     (lineOe),
    .engineHold (engineHold)
  );

endmodule

// File: tb/usb_line_force_bench.sv
module usb_line_force_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] forceCode = 2'b00;
  logic lowSpeed = 1'b0, polSwap = 1'b0;
  logic txDp = 1'b0, txDm = 1'b0, txOe = 1'b0;
  logic lineDp, lineDm, lineOe, engineHold;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t expQ[$];

  always #5 clk = ~clk;

  usb_line_force u_usb_line_force (
    .clk(clk), .rstN(rstN), .forceCode(forceCode), .lowSpeed(lowSpeed),
    .polSwap(polSwap), .txDp(txDp), .txDm(txDm), .txOe(txOe),
    .lineDp(lineDp), .lineDm(lineDm), .lineOe(lineOe), .engineHold(engineHold)
  );

  function automatic logic [3:0] model(logic [1:0] c, logic ls, logic ps,
                                       logic dp, logic dm, logic oe);
    logic sw;
    sw = ls & ps;
    case (c)
      2'b00:   return {dp, dm, oe, 1'b0};
      2'b01:   return 4'b0011;
      2'b10:   return sw ? 4'b0110 : 4'b1010;
      default: return sw ? 4'b1010 : 4'b0110;
    endcase
  endfunction

  function automatic string pickTag(logic [1:0] c, logic ls, logic ps);
    if (c == 2'b00) return (ls | ps) ? "R10 R2" : "R2";
    if (c == 2'b01) return "R3 R9 R8 R10";
    if (ls & ps)    return "R6 R8 R9";
    if (ls ^ ps)    return "R7 R8 R9";
    return (c == 2'b10) ? "R4 R8 R9" : "R5 R8 R9";
  endfunction

  task automatic check(logic [3:0] act, logic [3:0] exp, string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual dp,dm,oe,hold=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] c, logic ls, logic ps, logic dp, logic dm, logic oe);
    item_t it;
    @(negedge clk);
    forceCode = c; lowSpeed = ls; polSwap = ps;
    txDp = dp; txDm = dm; txOe = oe;
    it.exp = model(c, ls, ps, dp, dm, oe);
    it.tag = pickTag(c, ls, ps);
    expQ.push_back(it);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check({lineDp, lineDm, lineOe, engineHold}, it.exp, it.tag);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset holds outputs low even with active inputs
    forceCode = 2'b01; txDp = 1'b1; txOe = 1'b1;
    repeat (3) @(negedge clk);
    check({lineDp, lineDm, lineOe, engineHold}, 4'b0000, "R1");
    forceCode = 2'b10;
    @(negedge clk);
    check({lineDp, lineDm, lineOe, engineHold}, 4'b0000, "R1");
    forceCode = 2'b00; txDp = 1'b0; txOe = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 8; t++)
          drive(c[1:0], s[1], s[0], t[2], t[1], t[0]);
    // reset sequence: write reset code, hold, release
    drive(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    drive(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    if (expQ.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R2: actual %0d pending expected 0", expQ.size());
    end
    finish();
  end

endmodule